// File: doc/BRIEF.md
# Indirect Multichannel Pulse-Sample Store

This block holds custom pulse-shape samples for an eight-lane line transmitter. Each lane has its own small sample memory of 32 entries. The host never addresses these entries directly. It loads a pointer register, which packs a lane number and a sample index. It then moves samples through a single data register. An auto-increment option steps the sample index after each data access, so a whole shape can be streamed with one pointer write followed by a run of data accesses.

A write through the data register can reach several lanes at once. The target set is the lane named by the pointer plus every lane whose bit is set in a fan-out mask. Reads ignore that mask and return data only from the pointed lane. A per-lane select register drives outputs that tell the pulse shaper whether to use the stored shape or a preset one. The shaper also has an independent read port into the memories.

Top module: `wavesample_ctrl`

## Requirements
- R1: After reset, the fan-out mask, pointer, lane select and control registers all read 0, and `custom_en` is 0.
- R2: The host register addresses are 0x0F (control), 0x16 (fan-out mask), 0x17 (pointer), 0x18 (sample data) and 0x19 (lane select). A write stores its byte in the addressed register, and a read of that register returns the stored byte. A read of any other address returns 0.
- R3: When control bit 7 is 1, every read or write of 0x18 advances the sample index by one after the access. When that bit is 0, the index holds.
- R4: Data accesses and auto-increment never change the lane field of the pointer.
- R5: A write to 0x17 loads the lane number from bits [7:5] and the sample index from bits [4:0]. The next data access uses the new position.
- R6: A write to 0x18 stores the byte at the current sample index in every lane n for which fan-out mask bit n is 1.
- R7: A read of 0x18 returns, in the same cycle, the sample at the current index of the pointed lane only. The fan-out mask has no effect on reads.
- R8: Bit n of 0x19 drives `custom_en[n]`, starting the cycle after the write.
- R9: The pointed lane is written on a data write even when its own fan-out mask bit is 0.
- R10: Auto-increment from index 31 wraps to index 0.
- R11: `shp_sample` shows the stored sample at (`shp_ch`, `shp_ph`) combinationally. A host write to that location shows on `shp_sample` only from the following cycle.
- R12: When `host_rd` and `host_wr` are both high in the same cycle, the access acts as a write, and auto-increment advances the index only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rdata | output | 8 | Read data for the addressed register |
| shp_ch | input | 3 | Shaper lane select |
| shp_ph | input | 5 | Shaper sample index |
| shp_sample | output | 8 | Sample returned to the shaper |
| custom_en | output | 8 | Per-lane stored-shape select |

## Verification
Two functions can act on the same cycle. A host data write can land on the exact location that the shaper port is reading. A host access can also carry both strobes at once while auto-increment is on. The bench provokes the first case by pointing the shaper at the cell being rewritten. It expects the old sample in the write cycle and the new sample one cycle later. The second case is judged through the pointer readback, which must show a single step, and the fan-out result, which must match a write alone.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam logic [7:0] ADR_CTRL  = 8'h0F;
    localparam logic [7:0] ADR_FAN   = 8'h16;
    localparam logic [7:0] ADR_PTR   = 8'h17;
    localparam logic [7:0] ADR_DATA  = 8'h18;
    localparam logic [7:0] ADR_LSEL  = 8'h19;
    localparam int         AUTOINC_BIT = 7;
    localparam int         HOST_W      = 8;
endpackage

// File: rtl/wsr_regfile.sv
module wsr_regfile #(
    parameter int NUM_CH = 8,
    parameter int NUM_PH = 32,
    parameter int CH_W   = 3,
    parameter int PH_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_fan,
    input  logic                      wr_ptr,
    input  logic                      wr_lsel,
    input  logic                      wr_ctrl,
    input  logic                      data_acc,
    input  logic [wsr_pkg::HOST_W-1:0] wdata,
    output logic [NUM_CH-1:0]         fan_mask,
    output logic [CH_W-1:0]           ptr_ch,
    output logic [PH_W-1:0]           ptr_ph,
    output logic [NUM_CH-1:0]         lsel,
    output logic [wsr_pkg::HOST_W-1:0] ctrl,
    output logic                      autoinc
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_PH - 1);

    typedef struct packed {
        logic [NUM_CH-1:0]          fan;
        logic [CH_W-1:0]            ch;
        logic [PH_W-1:0]            ph;
        logic [NUM_CH-1:0]          lsel;
        logic [wsr_pkg::HOST_W-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (data_acc && regs_q.ctrl[wsr_pkg::AUTOINC_BIT]) begin
            regs_d.ph = (regs_q.ph == PH_LAST) ? '0 : regs_q.ph + 1'b1;
        end
        if (wr_fan)  regs_d.fan  = wdata[NUM_CH-1:0];
        if (wr_lsel) regs_d.lsel = wdata[NUM_CH-1:0];
        if (wr_ctrl) regs_d.ctrl = wdata;
        if (wr_ptr) begin
            regs_d.ch = wdata[PH_W +: CH_W];
            regs_d.ph = wdata[PH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign fan_mask = regs_q.fan;
    assign ptr_ch   = regs_q.ch;
    assign ptr_ph   = regs_q.ph;
    assign lsel     = regs_q.lsel;
    assign ctrl     = regs_q.ctrl;
    assign autoinc  = regs_q.ctrl[wsr_pkg::AUTOINC_BIT];
endmodule

// File: rtl/wsr_sample_bank.sv
module wsr_sample_bank #(
    parameter int NUM_CH = 8,
    parameter int NUM_PH = 32,
    parameter int SAMP_W = 8,
    parameter int CH_W   = 3,
    parameter int PH_W   = 5
) (
    input  logic              clk,
    input  logic [NUM_CH-1:0] we,
    input  logic [PH_W-1:0]   wr_ph,
    input  logic [SAMP_W-1:0] wr_data,
    input  logic [CH_W-1:0]   hst_ch,
    input  logic [PH_W-1:0]   hst_ph,
    output logic [SAMP_W-1:0] hst_sample,
    input  logic [CH_W-1:0]   shp_ch,
    input  logic [PH_W-1:0]   shp_ph,
    output logic [SAMP_W-1:0] shp_sample
);
    logic [SAMP_W-1:0] hst_lane [NUM_CH];
    logic [SAMP_W-1:0] shp_lane [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic [SAMP_W-1:0] mem_q [NUM_PH];
        always_ff @(posedge clk) begin
            if (we[c]) mem_q[wr_ph] <= wr_data;
        end
        assign hst_lane[c] = mem_q[hst_ph];
        assign shp_lane[c] = mem_q[shp_ph];
    end

    assign hst_sample = hst_lane[hst_ch];
    assign shp_sample = shp_lane[shp_ch];
endmodule

// File: rtl/wavesample_ctrl.sv
module wavesample_ctrl #(
    parameter int NUM_CH = 8,
    parameter int NUM_PH = 32,
    parameter int SAMP_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [wsr_pkg::HOST_W-1:0]     host_addr,
    input  logic [wsr_pkg::HOST_W-1:0]     host_wdata,
    input  logic                           host_rd,
    input  logic                           host_wr,
    output logic [wsr_pkg::HOST_W-1:0]     host_rdata,
    input  logic [$clog2(NUM_CH)-1:0]      shp_ch,
    input  logic [$clog2(NUM_PH)-1:0]      shp_ph,
    output logic [SAMP_W-1:0]              shp_sample,
    output logic [NUM_CH-1:0]              custom_en
);
    import wsr_pkg::*;

    localparam int CH_W = $clog2(NUM_CH);
    localparam int PH_W = $clog2(NUM_PH);

    logic              data_acc, data_wr;
    logic [NUM_CH-1:0] fan_mask, we;
    logic [CH_W-1:0]   ptr_ch;
    logic [PH_W-1:0]   ptr_ph;
    logic [HOST_W-1:0] ctrl;
    logic              autoinc;
    logic [SAMP_W-1:0] hst_sample;

    assign data_acc = (host_rd || host_wr) && (host_addr == ADR_DATA);
    assign data_wr  = host_wr && (host_addr == ADR_DATA);

    wsr_regfile #(
        .NUM_CH(NUM_CH), .NUM_PH(NUM_PH), .CH_W(CH_W), .PH_W(PH_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fan   (host_wr && (host_addr == ADR_FAN)),
        .wr_ptr   (host_wr && (host_addr == ADR_PTR)),
        .wr_lsel  (host_wr && (host_addr == ADR_LSEL)),
        .wr_ctrl  (host_wr && (host_addr == ADR_CTRL)),
        .data_acc (data_acc),
        .wdata    (host_wdata),
        .fan_mask (fan_mask),
        .ptr_ch   (ptr_ch),
        .ptr_ph   (ptr_ph),
        .lsel     (custom_en),
        .ctrl     (ctrl),
        .autoinc  (autoinc)
    );

    always_comb begin
        we = '0;
        if (data_wr) begin
            we = fan_mask;
            we[ptr_ch] = 1'b1;
        end
    end

    wsr_sample_bank #(
        .NUM_CH(NUM_CH), .NUM_PH(NUM_PH), .SAMP_W(SAMP_W), .CH_W(CH_W), .PH_W(PH_W)
    ) u_bank (
        .clk        (clk),
        .we         (we),
        .wr_ph      (ptr_ph),
        .wr_data    (host_wdata[SAMP_W-1:0]),
        .hst_ch     (ptr_ch),
        .hst_ph     (ptr_ph),
        .hst_sample (hst_sample),
        .shp_ch     (shp_ch),
        .shp_ph     (shp_ph),
        .shp_sample (shp_sample)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADR_CTRL: host_rdata = ctrl;
            ADR_FAN:  host_rdata = HOST_W'(fan_mask);
            ADR_PTR:  host_rdata = HOST_W'({ptr_ch, ptr_ph});
            ADR_DATA: host_rdata = HOST_W'(hst_sample);
            ADR_LSEL: host_rdata = HOST_W'(custom_en);
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int PH_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_rd,
    input logic              host_wr,
    input logic [CH_W-1:0]   ptr_ch,
    input logic [PH_W-1:0]   ptr_ph,
    input logic              autoinc,
    input logic [NUM_CH-1:0] custom_en
);
    logic acc18;
    assign acc18 = (host_rd || host_wr) && (host_addr == 8'h18);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc18 && autoinc) |=> (ptr_ph == PH_W'($past(ptr_ph) + 1'b1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc18 && !autoinc) |=> $stable(ptr_ph));

    p_lane_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc18 |=> $stable(ptr_ch));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h17) |=> ({ptr_ch, ptr_ph} == $past(host_wdata)));

    p_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h19) |=> (custom_en == $past(host_wdata[NUM_CH-1:0])));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd || host_wr) |=> ($stable(ptr_ch) && $stable(ptr_ph)));
endmodule

bind wavesample_ctrl wsr_checker #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .PH_W(PH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .ptr_ch     (ptr_ch),
    .ptr_ph     (ptr_ph),
    .autoinc    (autoinc),
    .custom_en  (custom_en)
);

// File: tb/test_wavesample_ctrl.sv
module test_wavesample_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [2:0] shp_ch = '0;
    logic [4:0] shp_ph = '0;
    logic [7:0] shp_sample, custom_en;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference model
    int         m_mem [8][32];
    bit         m_ok  [8][32];
    logic [7:0] m_fan = '0, m_lsel = '0, m_ctrl = '0;
    int         m_ch = 0, m_ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wavesample_ctrl i_wavesample_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .shp_ch(shp_ch), .shp_ph(shp_ph), .shp_sample(shp_sample), .custom_en(custom_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h0F:   return m_ctrl;
            8'h16:   return m_fan;
            8'h17:   return {3'(m_ch), 5'(m_ph)};
            8'h18:   return 8'(m_mem[m_ch][m_ph]);
            8'h19:   return m_lsel;
            default: return 8'h00;
        endcase
    endfunction

    task automatic cyc(input bit rd, input bit wr, input logic [7:0] a, input logic [7:0] d,
                       input string tag, input int sc = 0, input int sp = 0);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
        shp_ch = 3'(sc); shp_ph = 5'(sp);
        #1;
        if (rd && !wr && !(a == 8'h18 && !m_ok[m_ch][m_ph]))
            check(tag, host_rdata, m_read(a));
        check("R8", custom_en, m_lsel);
        if (m_ok[sc][sp]) check("R11", shp_sample, 8'(m_mem[sc][sp]));
        @(posedge clk);
        begin
            bit inc;
            inc = (rd || wr) && a == 8'h18 && m_ctrl[7];
            if (wr) begin
                case (a)
                    8'h0F: m_ctrl = d;
                    8'h16: m_fan  = d;
                    8'h17: begin m_ch = int'(d[7:5]); m_ph = int'(d[4:0]); end
                    8'h19: m_lsel = d;
                    8'h18: for (int c = 0; c < 8; c++)
                               if (c == m_ch || m_fan[c]) begin
                                   m_mem[c][m_ph] = int'(d); m_ok[c][m_ph] = 1'b1;
                               end
                    default: ;
                endcase
            end
            if (inc) m_ph = (m_ph + 1) % 32;
        end
    endtask

    task automatic idle();
        cyc(0, 0, 8'h00, 8'h00, "R1");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++)
            for (int p = 0; p < 32; p++) begin m_mem[c][p] = 0; m_ok[c][p] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state of every register
        cyc(1, 0, 8'h0F, 0, "R1");
        cyc(1, 0, 8'h16, 0, "R1");
        cyc(1, 0, 8'h17, 0, "R1");
        cyc(1, 0, 8'h19, 0, "R1");

        // R2: register storage and unmapped read
        cyc(0, 1, 8'h16, 8'hA5, "R2");
        cyc(1, 0, 8'h16, 0, "R2");
        cyc(0, 1, 8'h16, 8'h00, "R2");
        cyc(1, 0, 8'h33, 0, "R2");

        // R10, R3: stream 32 samples into lane 2, index wraps to 0
        cyc(0, 1, 8'h0F, 8'h80, "R2");
        cyc(0, 1, 8'h17, 8'h40, "R5");
        for (int p = 0; p < 32; p++) cyc(0, 1, 8'h18, 8'(8'h10 + p), "R3");
        cyc(1, 0, 8'h17, 0, "R10");
        // R7: mask set but read only returns lane 2
        cyc(0, 1, 8'h16, 8'hFF, "R2");
        for (int p = 0; p < 32; p++) cyc(1, 0, 8'h18, 0, "R7");
        cyc(1, 0, 8'h17, 0, "R4");
        cyc(0, 1, 8'h16, 8'h00, "R2");

        // R3: auto-increment off, index holds across reads
        cyc(0, 1, 8'h0F, 8'h00, "R2");
        cyc(0, 1, 8'h17, 8'h47, "R5");
        repeat (3) cyc(1, 0, 8'h18, 0, "R3");
        cyc(1, 0, 8'h17, 0, "R3");

        // R6, R9: fan-out to lanes 1 and 3, pointed lane 5 has mask bit 0
        cyc(0, 1, 8'h16, 8'h0A, "R2");
        cyc(0, 1, 8'h17, 8'hA3, "R5");
        cyc(0, 1, 8'h18, 8'h5C, "R6");
        cyc(0, 1, 8'h16, 8'h00, "R2");
        cyc(1, 0, 8'h18, 0, "R9");
        cyc(0, 1, 8'h17, 8'h23, "R5");
        cyc(1, 0, 8'h18, 0, "R6");
        cyc(0, 1, 8'h17, 8'h63, "R5");
        cyc(1, 0, 8'h18, 0, "R6");
        cyc(0, 1, 8'h17, 8'h83, "R5");
        m_ok[4][3] = 1'b0;
        cyc(1, 0, 8'h17, 0, "R4");

        // R8: lane select drives custom_en
        cyc(0, 1, 8'h19, 8'h96, "R2");
        idle();
        cyc(1, 0, 8'h19, 0, "R8");

        // R11: shaper reads a cell while the host overwrites it
        cyc(0, 1, 8'h17, 8'h47, "R5");
        cyc(0, 1, 8'h18, 8'hE1, "R11", 2, 7);
        cyc(0, 0, 8'h00, 0, "R11", 2, 7);

        // R12: both strobes on data register with auto-increment, one step
        cyc(0, 1, 8'h0F, 8'h80, "R2");
        cyc(0, 1, 8'h16, 8'h01, "R2");
        cyc(0, 1, 8'h17, 8'hDE, "R5");
        cyc(1, 1, 8'h18, 8'h77, "R12");
        cyc(1, 0, 8'h17, 0, "R12");
        cyc(0, 1, 8'h17, 8'hDE, "R5");
        cyc(1, 0, 8'h18, 0, "R12");
        cyc(0, 1, 8'h17, 8'h1E, "R5");
        cyc(1, 0, 8'h18, 0, "R12");

        // mixed random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: a = 8'h0F;
                1: a = 8'h16;
                2: a = 8'h17;
                3: a = 8'h19;
                4: a = 8'h2C;
                default: a = 8'h18;
            endcase
            cyc(1'($urandom), 1'($urandom), a, 8'($urandom), (a == 8'h18) ? "R7" : "R2",
                $urandom_range(0, 7), $urandom_range(0, 31));
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule